// File: doc/BRIEF.md
# Control-Loop Watchdog With Lockout

This block guards a three-phase power stage against a stalled control loop. The control software raises a one-cycle pulse on `tick` once per loop iteration, and the expected spacing of those pulses is given in clock cycles on `interval`. If the gap after a pulse grows beyond one and a half times that interval, the block pulls every gate-enable output low at once. It then latches a lockout. Only the power-on reset clears that lockout.

While locked out, the block flashes a status LED with a repeating code. The code is a group of short pulses followed by a long dark gap. The number of pulses comes from a 3-bit error code, which is captured at the moment of the trip. After power-on the watchdog stays disarmed, with the gates held off, until the first tick arrives. This gives the control loop time to start without tripping.

Top module: `loop_watchdog`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `gate_en` is all zeros, `lockout` is 0 and `led` is 0.
- R2: Before the first `tick` sampled high after reset the watchdog is disarmed: `gate_en` stays all zeros and no trip occurs, however long `tick` stays low.
- R3: The timeout threshold is TH = `interval` + floor(`interval`/2) clock cycles. After a tick sampled at clock edge E, `gate_en` becomes all ones from edge E. A following tick sampled at edge E+k with k <= TH is on time, keeps `gate_en` all ones and restarts the measurement.
- R4: If no tick is sampled at edges E+1 … E+TH after the last tick at edge E, `lockout` rises at edge E+TH+1. A tick arriving at E+TH+1 or later does not prevent the trip. With `interval` = 0 the trip happens at E+1.
- R5: In the same cycle that `lockout` rises, every bit of `gate_en` goes to 0.
- R6: Once set, `lockout` stays 1 and `gate_en` stays all zeros whatever happens on `tick`, `interval` or `err_code`. Only a low `rst_n` clears it.
- R7: While locked, `led` follows a repeating frame built from units of UNIT_CYC cycles. The frame is N pulses, each lit for one unit, with one dark unit between pulses. The last pulse is followed by GAP_UNITS dark units (default 5). A frame therefore lasts 2N+GAP_UNITS-1 units, and the first lit unit starts at the trip edge.
- R8: N is taken from `err_code` at the trip edge. Codes 1 to 7 give that many pulses, and code 0 gives 8. Later changes of `err_code` do not alter the pattern.
- R9: While `lockout` is 0, `led` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, the only lockout clear |
| tick | input | 1 | One-cycle pulse from the control loop |
| interval | input | CNT_W | Nominal tick spacing in clock cycles |
| err_code | input | 3 | Error code selecting the blink count |
| gate_en | output | NUM_GATES | Gate enables, 1 = switch may be driven, 0 = safe off |
| lockout | output | 1 | Latched watchdog trip |
| led | output | 1 | Blink-code status LED |

## Verification
A table of interval and gap pairs places each tick exactly at the threshold and one cycle past it. This is done for odd, even, unit, zero and full-scale intervals, so the halving rounding and the off-by-one at the boundary are both separated. Short gaps show that on-time ticks leave the gates enabled. A long silence before any tick separates disarmed behaviour from a trip. A run of ticks after a trip shows that the lockout ignores the loop. The LED is compared cycle by cycle over two frames for codes 3 and 0. The error code is changed mid-blink, which shows whether the code was captured or is being followed live.

// File: rtl/wdg_pkg.sv
// Shared definitions for the control-loop watchdog.
// Assumes a 3-bit error code; code 0 is shown as eight pulses.
package wdg_pkg;
    localparam int CODE_W     = 3;
    localparam int MAX_PULSES = 8;
    localparam int NP_W       = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NP_W-1:0]   npulse_t;

    // Map an error code to its blink-pulse count.
    function automatic npulse_t code_to_pulses(input code_t c);
        return (c == '0) ? npulse_t'(MAX_PULSES) : npulse_t'(c);
    endfunction
endpackage

// File: rtl/wdg_timer.sv
// Tick-gap timer: arms on the first tick, measures cycles since the last
// tick and flags a trip once the gap exceeds interval + interval/2.
// Assumes interval is held steady while armed; freezes when locked.
module wdg_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    input  logic             locked,
    output logic             armed,
    output logic             trip
);
    localparam int TH_W = CNT_W + 1;

    logic [TH_W-1:0] thresh;
    logic [TH_W-1:0] elapsed;

    // Threshold is one and a half intervals, rounded down.
    always_comb begin
        thresh = {1'b0, interval} + {2'b00, interval[CNT_W-1:1]};
    end

    // Arm on first tick and count cycles since the most recent tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            elapsed <= '0;
        end else if (!locked) begin
            if (tick) begin
                armed   <= 1'b1;
                elapsed <= '0;
            end else if (armed) begin
                elapsed <= elapsed + TH_W'(1);
            end
        end
    end

    // Trip once the measured gap has reached the threshold without a tick.
    always_comb begin
        trip = armed && !locked && (elapsed >= thresh);
    end

    p_tick_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !locked) |=> (elapsed == '0 && armed));

    p_trip_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> armed);
endmodule

// File: rtl/wdg_lock.sv
// Lockout latch: sets on a trip, captures the blink count from the
// error code at that edge, and clears only on reset.
module wdg_lock
    import wdg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    trip,
    input  code_t   err_code,
    output logic    locked,
    output npulse_t n_pulses
);
    // Latch the trip and freeze the pulse count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked   <= 1'b0;
            n_pulses <= '0;
        end else if (trip && !locked) begin
            locked   <= 1'b1;
            n_pulses <= code_to_pulses(err_code);
        end
    end

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    p_count_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(n_pulses));
endmodule

// File: rtl/wdg_blink.sv
// Blink sequencer: while locked, shows N one-unit pulses separated by one
// dark unit, then GAP_UNITS dark units, repeating. Idle and dark otherwise.
module wdg_blink
    import wdg_pkg::*;
#(
    parameter int UNIT_CYC  = 40_000_000,
    parameter int GAP_UNITS = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    locked,
    input  npulse_t n_pulses,
    output logic    led
);
    localparam int PRE_W  = $clog2(UNIT_CYC + 1);
    localparam int SLOT_W = $clog2(2 * MAX_PULSES + GAP_UNITS);

    logic [PRE_W-1:0]  pre;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] lit_end;
    logic [SLOT_W-1:0] last_slot;
    logic              unit_done;

    // Frame geometry from the captured pulse count.
    always_comb begin
        lit_end   = SLOT_W'({n_pulses, 1'b0});
        last_slot = lit_end + SLOT_W'(GAP_UNITS - 2);
        unit_done = (pre == PRE_W'(UNIT_CYC - 1));
    end

    // Advance the unit prescaler and the slot within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked) begin
            pre  <= '0;
            slot <= '0;
        end else if (unit_done) begin
            pre  <= '0;
            slot <= (slot >= last_slot) ? '0 : slot + SLOT_W'(1);
        end else begin
            pre <= pre + PRE_W'(1);
        end
    end

    // Lit on even slots inside the pulse group.
    always_comb begin
        led = locked && (slot < lit_end) && !slot[0];
    end

    p_led_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !led);

    p_slot_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (slot <= last_slot));
endmodule

// File: rtl/loop_watchdog.sv
// Control-loop watchdog top: gap timer, lockout latch and blink sequencer.
// Gate enables are high only while armed and not locked out.
module loop_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_GATES = 6,
    parameter int UNIT_CYC  = 40_000_000,
    parameter int GAP_UNITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [CNT_W-1:0]     interval,
    input  logic [CODE_W-1:0]    err_code,
    output logic [NUM_GATES-1:0] gate_en,
    output logic                 lockout,
    output logic                 led
);
    logic    armed;
    logic    trip;
    npulse_t n_pulses;

    wdg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .interval (interval),
        .locked   (lockout),
        .armed    (armed),
        .trip     (trip)
    );

    wdg_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip     (trip),
        .err_code (err_code),
        .locked   (lockout),
        .n_pulses (n_pulses)
    );

    wdg_blink #(.UNIT_CYC(UNIT_CYC), .GAP_UNITS(GAP_UNITS)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (lockout),
        .n_pulses (n_pulses),
        .led      (led)
    );

    // Every gate follows the same permit: armed and not locked out.
    always_comb begin
        gate_en = {NUM_GATES{armed && !lockout}};
    end

    p_gate_off_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> (gate_en == '0));

    p_gate_off_disarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (gate_en == '0));
endmodule

// File: tb/test_loop_watchdog.sv
`timescale 1ns/1ps
module test_loop_watchdog;
    localparam int CW  = 8;
    localparam int NG  = 6;
    localparam int U   = 4;
    localparam int GAP = 5;
    localparam logic [NG-1:0] ONES = {NG{1'b1}};

    typedef struct packed {
        logic [CW-1:0] iv;
        logic [9:0]    k;
        logic          late;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{iv: 8'd10,  k: 10'd15,  late: 1'b0},
        '{iv: 8'd10,  k: 10'd16,  late: 1'b1},
        '{iv: 8'd10,  k: 10'd5,   late: 1'b0},
        '{iv: 8'd7,   k: 10'd10,  late: 1'b0},
        '{iv: 8'd7,   k: 10'd11,  late: 1'b1},
        '{iv: 8'd1,   k: 10'd1,   late: 1'b0},
        '{iv: 8'd1,   k: 10'd2,   late: 1'b1},
        '{iv: 8'd0,   k: 10'd1,   late: 1'b1},
        '{iv: 8'd255, k: 10'd382, late: 1'b0},
        '{iv: 8'd255, k: 10'd383, late: 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] interval = '0;
    logic [2:0]    err_code = '0;
    logic [NG-1:0] gate_en;
    logic          lockout;
    logic          led;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    loop_watchdog #(.CNT_W(CW), .NUM_GATES(NG), .UNIT_CYC(U), .GAP_UNITS(GAP)) i_loop_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .interval(interval),
        .err_code(err_code), .gate_en(gate_en), .lockout(lockout), .led(led)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [CW-1:0] iv);
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; interval = iv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One tick sampled at a single rising edge; returns at the next falling edge.
    task automatic pulse_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Tick sampled k edges after the previous one.
    task automatic tick_after(input int k);
        repeat (k - 1) @(negedge clk);
        pulse_tick();
    endtask

    // Compare the LED over two frames, starting at the first locked negedge.
    task automatic check_blink(input string req, input int n, input logic [2:0] later_code);
        int frame_units;
        int bad;
        logic exp_led;
        frame_units = 2 * n + GAP - 1;
        bad = 0;
        for (int j = 0; j < 2 * frame_units * U; j++) begin
            int s;
            s = (j / U) % frame_units;
            exp_led = (s < 2 * n) && (s % 2 == 0);
            if (j == U + 1) err_code = later_code;
            if (led !== exp_led && bad == 0) begin
                bad = 1;
                $display("FAIL %s: led at cycle %0d actual %0b expected %0b", req, j, led, exp_led);
            end
            @(negedge clk);
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic wait_lock();
        while (lockout !== 1'b1) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 gate", gate_en, '0);
        check("R1 lockout", lockout, 0);
        check("R1 led", led, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 gate after release", gate_en, '0);

        // R2: disarmed for a long silence
        do_reset(8'd2);
        repeat (1000) @(negedge clk);
        check("R2 no trip", lockout, 0);
        check("R2 gate low", gate_en, '0);
        check("R9 led dark", led, 0);

        // R3/R4: vector table of tick gaps
        foreach (VECS[i]) begin
            do_reset(VECS[i].iv);
            pulse_tick();
            check("R3 gate armed", gate_en, ONES);
            tick_after(int'(VECS[i].k));
            check(VECS[i].late ? "R4 late trip" : "R3 on time", lockout, VECS[i].late);
            check("R5 gate", gate_en, VECS[i].late ? '0 : ONES);
        end

        // R4: exact trip edge, iv=10 -> TH=15
        do_reset(8'd10);
        pulse_tick();
        repeat (15) @(negedge clk);
        check("R4 before edge", lockout, 0);
        check("R3 gate before edge", gate_en, ONES);
        @(negedge clk);
        check("R4 at edge", lockout, 1);
        check("R5 gate at edge", gate_en, '0);

        // R6: ticks after trip ignored, reset clears
        for (int t = 0; t < 20; t++) pulse_tick();
        interval = 8'd200;
        repeat (10) @(negedge clk);
        check("R6 stays locked", lockout, 1);
        check("R6 gate off", gate_en, '0);
        do_reset(8'd10);
        @(negedge clk);
        check("R6 reset clears", lockout, 0);

        // R7/R8: blink code 3, code changed mid-blink
        err_code = 3'd3;
        do_reset(8'd2);
        pulse_tick();
        wait_lock();
        check_blink("R7 code3 R8 capture", 3, 3'd5);

        // R8: code 0 shows eight pulses
        err_code = 3'd0;
        do_reset(8'd2);
        pulse_tick();
        wait_lock();
        check_blink("R8 code0", 8, 3'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule